// File: doc/BRIEF.md
# Resonator Drive Amplitude Regulator

This block keeps the vibration amplitude of a driven resonator at a set level. Each time the sample strobe is high, it takes one signed detection sample and squares it. The square holds a constant term, set by the amplitude, and a term at twice the signal frequency. A first-order low-pass filter removes the double-frequency term and leaves an amplitude estimate.

The estimate is subtracted from a programmable setpoint. A proportional-integral controller turns that error into a non-negative gain. The same detection sample is multiplied by the current gain, and the product is the drive sample for the DAC path. Because the gain starts at a programmable value above unity, the oscillation can build up from rest. The controller then pulls the loop gain back toward one as the amplitude reaches the setpoint.

The setpoint, both controller coefficients, the integrator limits and the start-up gain are register inputs. All datapath values are two's-complement fixed point: samples and the setpoint are Q1.15, the gain is in units of 2^-GAIN_FRAC (4096 is unity by default), and the coefficients are in units of 2^-COEF_FRAC.

Top module: `amp_ctrl_loop`

## Requirements
- R1: A synchronous active-high reset sets the amplitude estimate to 0 and deasserts the drive-valid flag. It loads both the integrator and the gain output with `init_gain`.
- R2: On a strobe, the square term is floor(x*x / 2^15), saturated to 32767. The estimate then moves by floor((square - estimate) / 2^FILT_SH); when FILT_SH is 0 it takes the square directly. The new estimate appears at the port one cycle after the strobe.
- R3: When the strobe is low, the amplitude estimate does not change.
- R4: The error is `ref_amp` minus the estimate held before the strobe, saturated to the signed 16-bit range [-32768, 32767].
- R5: On each strobe, the integrator adds floor(error*ki / 2^COEF_FRAC) and the sum is clamped to [`int_lo`, `int_hi`].
- R6: On each strobe, the gain becomes floor(error*kp / 2^COEF_FRAC) plus the updated integrator, clamped to [0, 32767]. Between strobes the gain does not change.
- R7: One cycle after each strobe, `drv_vld` is high and `drv_out` is floor(x*g / 2^GAIN_FRAC), saturated to 16 bits, where g is the gain in effect before that strobe. Without a strobe, `drv_vld` is low and `drv_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_en | input | 1 | Sample strobe |
| smp_in | input | DW | Signed detection sample |
| ref_amp | input | DW | Signed amplitude setpoint |
| kp | input | DW | Signed proportional coefficient |
| ki | input | DW | Signed integral coefficient |
| int_lo | input | DW | Integrator lower limit |
| int_hi | input | DW | Integrator upper limit |
| init_gain | input | DW | Gain and integrator value loaded at reset |
| drv_out | output | DW | Signed drive sample |
| drv_vld | output | 1 | Drive sample valid, one cycle after strobe |
| amp_est | output | DW | Filtered amplitude estimate |
| gain_out | output | DW | Current non-negative gain |

## Verification
A wrong filter state shows on `amp_est` at the next strobe. Because the error uses that estimate, the fault reaches `gain_out` at the same edge and reaches `drv_out` one strobe later. A wrong integrator is hidden until the sum falls outside its clamps. For that reason the stimulus drives the integrator into both limits and holds it there, so a fault appears in `gain_out` within a few samples. The case where the error itself saturates is exercised with the proportional coefficient set to zero, so that its effect on the integrator can be seen through the gain.

// File: rtl/acl_pkg.sv
package acl_pkg;
   typedef logic signed [63:0] wide_t;

   function automatic wide_t smax(input int unsigned w);
      return (64'sd1 <<< (w - 1)) - 64'sd1;
   endfunction

   function automatic wide_t smin(input int unsigned w);
      return -(64'sd1 <<< (w - 1));
   endfunction

   function automatic wide_t clip(input wide_t v, input wide_t lo, input wide_t hi);
      if (v > hi) return hi;
      if (v < lo) return lo;
      return v;
   endfunction
endpackage

// File: rtl/acl_amp_det.sv
module acl_amp_det #(
   parameter int DW      = 16,
   parameter int FILT_SH = 4
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 smp_en,
   input  logic signed [DW-1:0] smp_in,
   output logic signed [DW-1:0] amp
);
   import acl_pkg::*;

   localparam int SQ_SH = DW - 1;

   if (FILT_SH < 0 || FILT_SH > DW - 2) begin : g_bad_sh
      $error("acl_amp_det: FILT_SH out of range");
   end

   wide_t sq_w, x_w;
   logic signed [DW-1:0] sq, amp_nxt;

   always_comb begin
      x_w  = wide_t'(smp_in);
      sq_w = clip((x_w * x_w) >>> SQ_SH, 64'sd0, smax(DW));
      sq   = DW'(sq_w);
   end

   if (FILT_SH == 0) begin : g_bypass
      always_comb amp_nxt = sq;
   end else begin : g_iir
      wide_t diff_w;
      always_comb begin
         diff_w  = wide_t'(sq) - wide_t'(amp);
         amp_nxt = DW'(wide_t'(amp) + (diff_w >>> FILT_SH));
      end
   end

   always_ff @(posedge clk) begin
      if (rst)         amp <= '0;
      else if (smp_en) amp <= amp_nxt;
   end

   // R1
   amp_rst_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (amp == '0));

   // R3
   amp_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !smp_en |=> $stable(amp));
endmodule

// File: rtl/acl_pi.sv
module acl_pi #(
   parameter int DW        = 16,
   parameter int COEF_FRAC = 8
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 smp_en,
   input  logic signed [DW-1:0] amp,
   input  logic signed [DW-1:0] ref_amp,
   input  logic signed [DW-1:0] kp,
   input  logic signed [DW-1:0] ki,
   input  logic signed [DW-1:0] int_lo,
   input  logic signed [DW-1:0] int_hi,
   input  logic signed [DW-1:0] init_gain,
   output logic signed [DW-1:0] gain
);
   import acl_pkg::*;

   if (COEF_FRAC < 0 || COEF_FRAC > 2 * DW - 2) begin : g_bad_cf
      $error("acl_pi: COEF_FRAC out of range");
   end

   logic signed [DW-1:0] acc, acc_nxt, gain_nxt, err;
   wide_t err_w, i_w, p_w;

   always_comb begin
      err_w    = clip(wide_t'(ref_amp) - wide_t'(amp), smin(DW), smax(DW));
      err      = DW'(err_w);
      i_w      = (wide_t'(err) * wide_t'(ki)) >>> COEF_FRAC;
      p_w      = (wide_t'(err) * wide_t'(kp)) >>> COEF_FRAC;
      acc_nxt  = DW'(clip(wide_t'(acc) + i_w, wide_t'(int_lo), wide_t'(int_hi)));
      gain_nxt = DW'(clip(p_w + wide_t'(acc_nxt), 64'sd0, smax(DW)));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         acc  <= init_gain;
         gain <= init_gain;
      end else if (smp_en) begin
         acc  <= acc_nxt;
         gain <= gain_nxt;
      end
   end

   // R5
   acc_lim_chk: assert property (@(posedge clk) disable iff (rst)
      (smp_en && (int_lo <= int_hi)) |=>
         ((acc >= $past(int_lo)) && (acc <= $past(int_hi))));

   // R6
   gain_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !smp_en |=> $stable(gain));
endmodule

// File: rtl/acl_drive_mul.sv
module acl_drive_mul #(
   parameter int DW        = 16,
   parameter int GAIN_FRAC = 12
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 smp_en,
   input  logic signed [DW-1:0] smp_in,
   input  logic signed [DW-1:0] gain,
   output logic signed [DW-1:0] drv_out,
   output logic                 drv_vld
);
   import acl_pkg::*;

   if (GAIN_FRAC < 0 || GAIN_FRAC > DW - 1) begin : g_bad_gf
      $error("acl_drive_mul: GAIN_FRAC out of range");
   end

   logic signed [DW-1:0] drv_nxt;

   always_comb
      drv_nxt = DW'(clip((wide_t'(smp_in) * wide_t'(gain)) >>> GAIN_FRAC,
                         smin(DW), smax(DW)));

   always_ff @(posedge clk) begin
      if (rst) begin
         drv_out <= '0;
         drv_vld <= 1'b0;
      end else begin
         drv_vld <= smp_en;
         if (smp_en) drv_out <= drv_nxt;
      end
   end

   // R7
   vld_track_chk: assert property (@(posedge clk) disable iff (rst)
      smp_en |=> drv_vld);

   // R7
   drv_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !smp_en |=> (!drv_vld && $stable(drv_out)));
endmodule

// File: rtl/amp_ctrl_loop.sv
module amp_ctrl_loop #(
   parameter int DW        = 16,
   parameter int FILT_SH   = 4,
   parameter int COEF_FRAC = 8,
   parameter int GAIN_FRAC = 12
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 smp_en,
   input  logic signed [DW-1:0] smp_in,
   input  logic signed [DW-1:0] ref_amp,
   input  logic signed [DW-1:0] kp,
   input  logic signed [DW-1:0] ki,
   input  logic signed [DW-1:0] int_lo,
   input  logic signed [DW-1:0] int_hi,
   input  logic signed [DW-1:0] init_gain,
   output logic signed [DW-1:0] drv_out,
   output logic                 drv_vld,
   output logic signed [DW-1:0] amp_est,
   output logic signed [DW-1:0] gain_out
);
   if (DW < 4 || DW > 24) begin : g_bad_dw
      $error("amp_ctrl_loop: DW must lie in 4..24");
   end

   acl_amp_det #(.DW(DW), .FILT_SH(FILT_SH)) u_det (
      .clk(clk), .rst(rst), .smp_en(smp_en), .smp_in(smp_in), .amp(amp_est)
   );

   acl_pi #(.DW(DW), .COEF_FRAC(COEF_FRAC)) u_pi (
      .clk(clk), .rst(rst), .smp_en(smp_en), .amp(amp_est),
      .ref_amp(ref_amp), .kp(kp), .ki(ki), .int_lo(int_lo),
      .int_hi(int_hi), .init_gain(init_gain), .gain(gain_out)
   );

   acl_drive_mul #(.DW(DW), .GAIN_FRAC(GAIN_FRAC)) u_mul (
      .clk(clk), .rst(rst), .smp_en(smp_en), .smp_in(smp_in),
      .gain(gain_out), .drv_out(drv_out), .drv_vld(drv_vld)
   );
endmodule

// File: tb/amp_ctrl_loop_tb.sv
module amp_ctrl_loop_tb;
   localparam int DW = 16, FSH = 4, CF = 8, GF = 12;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic smp_en = 1'b0;
   logic signed [DW-1:0] smp_in = '0, ref_amp = '0, kp = '0, ki = '0;
   logic signed [DW-1:0] int_lo = '0, int_hi = '0, init_gain = '0;
   logic signed [DW-1:0] drv_out, amp_est, gain_out;
   logic drv_vld;

   int n_chk = 0, n_err = 0;
   longint exp_q[$];
   longint m_y, m_acc, m_g;

   always #10 clk = ~clk;

   amp_ctrl_loop #(.DW(DW), .FILT_SH(FSH), .COEF_FRAC(CF), .GAIN_FRAC(GF)) u_dut (
      .clk(clk), .rst(rst), .smp_en(smp_en), .smp_in(smp_in), .ref_amp(ref_amp),
      .kp(kp), .ki(ki), .int_lo(int_lo), .int_hi(int_hi), .init_gain(init_gain),
      .drv_out(drv_out), .drv_vld(drv_vld), .amp_est(amp_est), .gain_out(gain_out)
   );

   function automatic longint clipl(longint v, longint lo, longint hi);
      if (v > hi) return hi;
      if (v < lo) return lo;
      return v;
   endfunction

   task automatic chk(string tag, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Monitor: pops expected drive samples as the design produces them (R7)
   always @(negedge clk) begin
      if (!rst && drv_vld) begin
         if (exp_q.size() == 0) chk("R7 unexpected drv_vld", 1, 0);
         else chk("R7 drv_out", longint'(drv_out), exp_q.pop_front());
      end
   end

   task automatic do_reset(longint g0);
      rst = 1'b1; smp_en = 1'b0; init_gain = DW'(g0);
      @(negedge clk); @(negedge clk);
      rst = 1'b0;
      m_y = 0; m_acc = g0; m_g = g0;
      exp_q.delete();
      chk("R1 amp_est", longint'(amp_est), 0);
      chk("R1 gain_out", longint'(gain_out), g0);
      chk("R1 drv_vld", longint'(drv_vld), 0);
   endtask

   // Driver: applies one strobe, pushes the expected drive, checks state
   task automatic step(longint x);
      longint sq, e, a, g, d;
      smp_in = DW'(x); smp_en = 1'b1;
      sq = clipl((x * x) >>> 15, 0, 32767);
      e  = clipl(longint'(ref_amp) - m_y, -32768, 32767);                      // R4
      a  = clipl(m_acc + ((e * longint'(ki)) >>> CF), longint'(int_lo), longint'(int_hi)); // R5
      g  = clipl(((e * longint'(kp)) >>> CF) + a, 0, 32767);                  // R6
      d  = clipl((x * m_g) >>> GF, -32768, 32767);                             // R7
      exp_q.push_back(d);
      m_y = (FSH == 0) ? sq : m_y + ((sq - m_y) >>> FSH);
      m_acc = a; m_g = g;
      @(negedge clk);
      smp_en = 1'b0;
      chk("R2 amp_est", longint'(amp_est), m_y);
      chk("R6 gain_out", longint'(gain_out), m_g);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         chk("R3 amp_est hold", longint'(amp_est), m_y);
         chk("R6 gain hold", longint'(gain_out), m_g);
         chk("R7 drv_vld idle", longint'(drv_vld), 0);
      end
   endtask

   task automatic sine(int cnt, real ampl);
      for (int k = 0; k < cnt; k++)
         step(longint'($rtoi(ampl * $sin(6.283185307 * k / 32.0))));
   endtask

   initial begin
      @(negedge clk);
      // Start-up above unity, normal regulation
      ref_amp = 12000; kp = 64; ki = 8; int_lo = 0; int_hi = 20000;
      do_reset(6000);
      sine(128, 20000.0);
      idle(5);
      // R2 square saturation at full negative scale, R7 drive saturation
      step(-32768); step(-32768); step(32767); step(32767);
      idle(2);
      // R5 lower integrator limit, R6 gain floor at zero
      ref_amp = 0;
      sine(48, 9000.0);
      idle(3);
      // R5 upper integrator limit
      ref_amp = 30000; ki = 200; int_hi = 9000;
      sine(40, 1000.0);
      idle(3);
      // R4 error saturation seen through the integrator with kp = 0
      kp = 0; ki = 1; int_lo = -32768; int_hi = 32767; ref_amp = -32768;
      do_reset(30000);
      for (int k = 0; k < 20; k++) step(32767);
      idle(3);
      chk("R7 queue drained", exp_q.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      #(20 * 150000);
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule